// File: doc/BRIEF.md
# Receive Character FIFO with Ready and Status Accumulation

This block sits between a serial receiver and the processor or DMA engine. The receiver writes each assembled 8-bit character into a 16-entry FIFO, together with four status flags: parity error, framing error, end-of-message and compare match. The reader takes the oldest entry from a head view that is always visible, and pops it with a read strobe.

A ready flag tells the reader to come for data. It has two modes. In not-empty mode every accepted write raises it. In threshold mode it rises only when the fill level reaches a programmed value, or when one of four urgent events occurs. A processor clear keeps ready low until a new event raises it again. Ready drives an interrupt line through two enables and a DMA request through a mode bit.

A status register collects the flags of each entry as that entry becomes the head of the FIFO. It also holds a sticky overrun bit. Software clears any bit by writing 1 to it. This lets it gather status one character at a time or over a whole frame.

Top module: `rx_status_fifo`

## Requirements
- R1: The FIFO holds up to 16 entries of {wr_stat[3:0], wr_data[7:0]} in first-in first-out order. While it is not empty, rd_data and rd_stat show the oldest entry. level counts the entries, and empty and full follow level. All of these update on the clock edge that accepts a write or a pop.
- R2: A write while full is dropped, even if a read occurs in the same cycle, and sets stat_reg[4] (overrun). A read while empty is ignored.
- R3: With thr_mode=0, every accepted write sets rdy on the next edge.
- R4: A pop that leaves the FIFO empty clears rdy on that edge, unless a set event occurs in the same cycle.
- R5: With thr_mode=1, an accepted write sets rdy when the level after that edge equals thr_level (1 to 16).
- R6: With thr_mode=1, rdy is also set, whatever the fill level, by any of: an accepted write whose wr_stat[2] (end-of-message) is 1, a cnt_event pulse, a brk_event pulse, or a wdt_event pulse.
- R7: rdy_clear drives rdy low on the next edge. rdy then stays low whatever the FIFO holds until a set event occurs. A set event in the same cycle as rdy_clear wins.
- R8: When an entry becomes the head, its status bits are ORed into stat_reg[3:0]. An entry becomes the head either by being written into an empty FIFO (or into a FIFO that the same cycle's pop empties) or by being exposed when the entry in front of it is popped. The bit meanings are: bit0 parity error, bit1 framing error, bit2 end-of-message, bit3 compare match.
- R9: stat_clr_we clears every stat_reg bit whose stat_clr_mask bit is 1. A bit being set in the same cycle stays set.
- R10: irq equals rdy AND irq_en AND master_en. dma_req equals rdy AND dma_mode. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write a character |
| wr_data | input | 8 | Character to write |
| wr_stat | input | 4 | Status flags of the character |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head character |
| rd_stat | output | 4 | Head status flags |
| level | output | 5 | Number of stored entries |
| empty | output | 1 | FIFO is empty |
| full | output | 1 | FIFO is full |
| thr_mode | input | 1 | 0 = not-empty mode, 1 = threshold mode |
| thr_level | input | 5 | Threshold level, 1 to 16 |
| cnt_event | input | 1 | Character-count terminal pulse |
| brk_event | input | 1 | Break-start pulse |
| wdt_event | input | 1 | Watchdog timeout pulse |
| rdy_clear | input | 1 | Processor clear of ready |
| rdy | output | 1 | Ready flag |
| stat_reg | output | 5 | Accumulated status, bit4 = overrun |
| stat_clr_we | input | 1 | Clear strobe for stat_reg |
| stat_clr_mask | input | 5 | Bits of stat_reg to clear |
| irq_en | input | 1 | Ready interrupt enable |
| master_en | input | 1 | Channel master interrupt enable |
| dma_mode | input | 1 | Route ready to DMA request |
| irq | output | 1 | Interrupt output |
| dma_req | output | 1 | DMA request output |

## Verification
Random phases change the write and read rates so that the FIFO hovers near empty, drains, or saturates. This separates the automatic negation of ready on draining from the drop-and-overrun behaviour when full. The phases also switch between the two ready modes and sweep the threshold across its range, so a level-triggered set can be told apart from an event-triggered set. Directed runs fill the FIFO past 16 entries, raise a break while the FIFO is empty, and issue clears together with set events, to confirm which of the two wins. Sparse clear strobes with random masks show whether status is accumulated or replaced.

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DEPTH   = 16,
  parameter int DW      = 8,
  parameter int SW      = 4,
  parameter int EOM_BIT = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [DW-1:0]                  wr_data,
  input  logic [SW-1:0]                  wr_stat,
  input  logic                           rd_en,
  output logic [DW-1:0]                  rd_data,
  output logic [SW-1:0]                  rd_stat,
  output logic [$clog2(DEPTH):0]         level,
  output logic                           empty,
  output logic                           full,
  input  logic                           thr_mode,
  input  logic [$clog2(DEPTH):0]         thr_level,
  input  logic                           cnt_event,
  input  logic                           brk_event,
  input  logic                           wdt_event,
  input  logic                           rdy_clear,
  output logic                           rdy,
  output logic [SW:0]                    stat_reg,
  input  logic                           stat_clr_we,
  input  logic [SW:0]                    stat_clr_mask,
  input  logic                           irq_en,
  input  logic                           master_en,
  input  logic                           dma_mode,
  output logic                           irq,
  output logic                           dma_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW+SW-1:0] mem [DEPTH];
  logic [AW-1:0]    rptr, wptr, rptr1, wptr1;
  logic [LW-1:0]    lvl_nxt;
  logic [SW-1:0]    head_in;
  logic             pop, push, ovr, thr_hit, rdy_set;

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign pop   = rd_en & ~empty;
  assign push  = wr_en & ~full;
  assign ovr   = wr_en & full;
  assign lvl_nxt = level + LW'(push) - LW'(pop);

  assign rptr1 = (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
  assign wptr1 = (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;

  assign rd_data = mem[rptr][DW-1:0];
  assign rd_stat = mem[rptr][DW+SW-1:DW];

  always_comb begin
    head_in = '0;
    if (pop && level > LW'(1))
      head_in = mem[rptr1][DW+SW-1:DW];
    else if (push && (empty || (pop && level == LW'(1))))
      head_in = wr_stat;
  end

  assign thr_hit = push & (lvl_nxt == thr_level);
  assign rdy_set = thr_mode ? (thr_hit | (push & wr_stat[EOM_BIT]) | cnt_event | brk_event | wdt_event)
                            : push;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {wr_stat, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      wptr     <= '0;
      level    <= '0;
      rdy      <= 1'b0;
      stat_reg <= '0;
    end else begin
      if (pop)  rptr <= rptr1;
      if (push) wptr <= wptr1;
      level <= lvl_nxt;
      if (rdy_set)                        rdy <= 1'b1;
      else if (rdy_clear)                 rdy <= 1'b0;
      else if (pop && lvl_nxt == '0)      rdy <= 1'b0;
      stat_reg <= (stat_reg & ~(stat_clr_we ? stat_clr_mask : '0)) | {ovr, head_in};
    end
  end

  assign irq     = rdy & irq_en & master_en;
  assign dma_req = rdy & dma_mode;

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_overrun_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> stat_reg[SW]);

  assert_empty_read_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> empty);

  assert_write_sets_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_mode && wr_en && !full) |=> rdy);

  assert_drain_negates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_mode && rd_en && level == LW'(1) && !wr_en) |=> (!rdy && empty));

  assert_break_sets_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_mode && brk_event) |=> rdy);

  assert_clear_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_mode && rdy_clear && !wr_en) |=> !rdy);
endmodule

// File: tb/tb_rx_status_fifo.sv
module tb_rx_status_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       wr_en = 0, rd_en = 0, thr_mode = 0, cnt_event = 0, brk_event = 0, wdt_event = 0;
  logic       rdy_clear = 0, stat_clr_we = 0, irq_en = 0, master_en = 0, dma_mode = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] wr_stat = 0;
  logic [4:0] thr_level = 5'd1, stat_clr_mask = 0;
  logic [7:0] rd_data;
  logic [3:0] rd_stat;
  logic [4:0] level, stat_reg;
  logic       empty, full, rdy, irq, dma_req;

  rx_status_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat),
    .rd_en(rd_en), .rd_data(rd_data), .rd_stat(rd_stat), .level(level), .empty(empty),
    .full(full), .thr_mode(thr_mode), .thr_level(thr_level), .cnt_event(cnt_event),
    .brk_event(brk_event), .wdt_event(wdt_event), .rdy_clear(rdy_clear), .rdy(rdy),
    .stat_reg(stat_reg), .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask),
    .irq_en(irq_en), .master_en(master_en), .dma_mode(dma_mode), .irq(irq), .dma_req(dma_req)
  );

  int checks = 0, errors = 0;
  logic [11:0] q[$];
  bit          m_rdy = 0;
  logic [4:0]  m_stat = 0;
  string       rdy_tag = "R7", stat_tag = "R8";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1", "level", level, q.size());
    chk("R1", "empty", empty, q.size() == 0);
    chk("R1", "full", full, q.size() == 16);
    if (q.size() > 0) begin
      chk("R1", "rd_data", rd_data, q[0][7:0]);
      chk("R1", "rd_stat", rd_stat, q[0][11:8]);
    end
    chk(rdy_tag, "rdy", rdy, m_rdy);
    chk(stat_tag, "stat_reg", stat_reg, m_stat);
    chk("R10", "irq", irq, m_rdy & irq_en & master_en);
    chk("R10", "dma_req", dma_req, m_rdy & dma_mode);
  endtask

  // reference update from the requirements, applied for the coming edge
  task automatic model_step();
    int sz, post;
    bit pp, ps, ov, set;
    logic [3:0] hi;
    sz = q.size();
    pp = rd_en && sz > 0;
    ps = wr_en && sz < 16;
    ov = wr_en && sz == 16;
    hi = 4'd0;
    if (pp && sz > 1) hi = q[1][11:8];
    else if (ps && (sz == 0 || (pp && sz == 1))) hi = wr_stat;
    post = sz + int'(ps) - int'(pp);
    if (thr_mode) set = (ps && post == int'(thr_level)) || (ps && wr_stat[2]) || cnt_event || brk_event || wdt_event;
    else          set = ps;
    if (set) begin m_rdy = 1; rdy_tag = thr_mode ? ((ps && post == int'(thr_level)) ? "R5" : "R6") : "R3"; end
    else if (rdy_clear) begin m_rdy = 0; rdy_tag = "R7"; end
    else if (pp && post == 0) begin m_rdy = 0; rdy_tag = "R4"; end
    stat_tag = ov ? "R2" : (stat_clr_we ? "R9" : "R8");
    m_stat = (m_stat & ~(stat_clr_we ? stat_clr_mask : 5'd0)) | {ov, hi};
    if (pp) void'(q.pop_front());
    if (ps) q.push_back({wr_stat, wr_data});
  endtask

  task automatic cyc(bit w, bit r, bit c, bit ce, bit be, bit we, bit scw, logic [4:0] scm);
    wr_en = w; rd_en = r; rdy_clear = c; cnt_event = ce; brk_event = be; wdt_event = we;
    stat_clr_we = scw; stat_clr_mask = scm;
    wr_data = 8'($urandom); wr_stat = 4'($urandom);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    // R2: overfill in not-empty mode, then clear status
    irq_en = 1; master_en = 1; dma_mode = 1;
    for (int i = 0; i < 18; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 1, 5'h1f);
    // R7: ready held low while FIFO holds data
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    // R4: drain fully
    for (int i = 0; i < 18; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0);
    // R6: break while empty in threshold mode, clear together with event
    thr_mode = 1; thr_level = 5'd16;
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    // R5: fill to 16 in threshold mode
    for (int i = 0; i < 17; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 17; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0);
    // random phases
    for (int ph = 0; ph < 24; ph++) begin
      int pw, pr;
      thr_mode  = 1'($urandom);
      thr_level = 5'(1 + $urandom_range(15));
      irq_en = 1'($urandom); master_en = 1'($urandom); dma_mode = 1'($urandom);
      pw = $urandom_range(90, 10);
      pr = $urandom_range(90, 10);
      for (int i = 0; i < 200; i++)
        cyc($urandom_range(99) < pw, $urandom_range(99) < pr, $urandom_range(99) < 5,
            $urandom_range(99) < 2, $urandom_range(99) < 2, $urandom_range(99) < 2,
            $urandom_range(99) < 6, 5'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule